// File: doc/BRIEF.md
# SPI Master Core with Run/Pause/Reset Control

This block is a byte-oriented SPI master driven through a small register port. Software moves the core between three operating states (reset, run and pause) by writing a state register. After each accepted state write, a settle flag goes low for a fixed two-cycle window. Software waits for the flag to return high before it requests another change. Bytes to send are queued in an 8-entry transmit FIFO. Bytes received on the serial input are collected in an 8-entry receive FIFO. Shifting happens only while the core is in the run state.

Each run is bounded by two 16-bit byte limits. The send limit stops the shifter once that many bytes have left the core. The receive limit stops bytes from being stored once that many have been captured. A limit of zero turns its limit off. The serial clock comes from a programmable half-period divider, and the four standard SPI modes are chosen with two configuration bits: the clock idle level and the sample-on-leading-edge bit. An internal loopback connects the serial output back to the sampler. A software reset register returns the whole core to its power-on state. To read a peripheral, software keeps the send limit equal to the receive limit and pushes one 0xFF filler byte for each byte it expects, so that the clock keeps running.

Top module: `spim_core`

## Requirements
- R1: After reset the core is in the reset state. The state register reads 0x0004 (bit 2 is the settle flag, bits 1:0 hold the state code). The configuration register, both limits and the status register read 0. The divider reads 2. `sclk` is 0 and `mosi_oe` is 0.
- R2: The state codes are reset=00, run=01 and pause=11. An accepted write to the state register (address 0) sets the new code. The settle flag then reads 0 for exactly the two cycles after the write edge and reads 1 again on the third.
- R3: A state write is ignored while the settle flag is 0. A write of the unused code 10 is also ignored and does not drop the settle flag.
- R4: Bytes are shifted only in the run state. In pause, queued bytes stay in the transmit FIFO and `sclk` stays at its idle level. In the reset state, writes to the transmit data register (address 6) are ignored.
- R5: Configuration register (address 1) fields: bit0 output enable, bit1 input enable, bit2 loopback, bit3 clock idles high, bit4 sample on the leading edge, bit5 keep the output driven. Modes 0 and 2 set bit4; modes 2 and 3 set bit3. `sclk` idles at bit3. Data goes out MSB first, and it is stable at the edge on which the receiver samples.
- R6: Each byte takes 16 `sclk` edges, and the edges are max(D,1) core cycles apart, where D is the divider register (address 2).
- R7: With loopback set, the sampler takes the core's own serial output and ignores `miso`. With loopback clear, it takes `miso`.
- R8: When the send limit (address 3) is nonzero, the core stops after sending that many bytes. Status bit3 (limit reached) then stays set, and transmit pushes are ignored until the core returns to the reset state.
- R9: When the receive limit (address 4) is nonzero, only that many received bytes are stored. Later bytes are still sent but are dropped on receive.
- R10: A limit value of zero disables that limit, and status bit3 stays 0.
- R11: Each FIFO holds 8 bytes. Status bit0 reports transmit FIFO full, bit1 transmit FIFO not empty, and bit2 receive FIFO not empty. Pushes into a full FIFO are ignored. Reading address 7 returns and removes the oldest received byte.
- R12: Entering the reset state empties both FIFOs and clears the transfer counts.
- R13: Writing 1 in bit0 of address 8 restores every register to its reset value. It also empties both FIFOs and leaves the core in the reset state with the settle flag at 1.
- R14: When output enable is 0, `mosi` stays at 1. When input enable is 0, nothing is stored in the receive FIFO. `mosi_oe` is 1 whenever a byte is being shifted or the keep-driven bit is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 7 pops the receive FIFO) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The two-cycle settle window is the hardest case to reach from the ports. A second state write has to land exactly on the edge where the flag still reads 0 and its counter is just reaching zero. The bench places back-to-back writes one cycle apart, then reads the settle flag cycle by cycle. The full-FIFO and limit-reached corners depend on bytes sitting idle in the transmit queue, so the bench loads the queue in the pause state, where nothing shifts, and only then releases it into run. The mode and divider sweep checks the output bits and the edge spacing through a bench monitor on `sclk`. It alternates loopback with an inverting external return path, so the two sampler sources give different bytes.

// File: rtl/spim_pkg.sv
// Shared types and register addresses for the SPI master core.
package spim_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_RUN   = 2'b01,
        ST_PAUSE = 2'b11
    } core_state_e;

    // Configuration fields; out_en lands on bit 0.
    typedef struct packed {
        logic keep_drive;
        logic lead_sample;
        logic idle_high;
        logic loopback;
        logic in_en;
        logic out_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [3:0] A_STATE = 4'd0;
    localparam logic [3:0] A_CFG   = 4'd1;
    localparam logic [3:0] A_DIV   = 4'd2;
    localparam logic [3:0] A_OLIM  = 4'd3;
    localparam logic [3:0] A_ILIM  = 4'd4;
    localparam logic [3:0] A_STAT  = 4'd5;
    localparam logic [3:0] A_TXD   = 4'd6;
    localparam logic [3:0] A_RXD   = 4'd7;
    localparam logic [3:0] A_SWRST = 4'd8;

endpackage

// File: rtl/spim_fifo.sv
// Synchronous FIFO used for both byte queues.
// Assumes: pushes into a full FIFO and pops from an empty one are dropped;
// flush empties the FIFO in one cycle and wins over push and pop.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (push_ok && !pop_ok)      cnt <= cnt + CW'(1);
            else if (pop_ok && !push_ok) cnt <= cnt - CW'(1);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R11
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/spim_shifter.sv
// Serial byte engine: produces sclk from a half-period divider and shifts
// one byte MSB first in any of the four SPI modes.
// Assumes: start is only honoured while idle; srst_n is a synchronous clear
// that also aborts a byte in flight.
module spim_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] half_div,
    input  logic             idle_high,
    input  logic             lead_sample,
    input  logic             out_en,
    input  logic             loopback,
    input  logic             miso,
    output logic             busy,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic             sclk,
    output logic             mosi
);
    localparam logic [3:0] LAST_HALF = 4'd15;

    logic [DIV_W-1:0] tick, div_eff;
    logic [3:0]       half_idx;
    logic             phase, mosi_q, busy_q, done_q;
    logic [7:0]       tx_sh, rx_sh;
    logic             half_end, leading, do_sample, do_drive, sample_bit;

    assign div_eff    = (half_div == '0) ? DIV_W'(1) : half_div;
    assign half_end   = busy_q && (tick == div_eff - DIV_W'(1));
    assign leading    = ~half_idx[0];
    assign do_sample  = half_end && (leading == lead_sample);
    assign do_drive   = half_end && (leading != lead_sample) && (half_idx != LAST_HALF);
    assign mosi       = out_en ? mosi_q : 1'b1;
    assign sample_bit = loopback ? mosi : miso;
    assign sclk       = phase ^ idle_high;
    assign busy       = busy_q;
    assign byte_done  = done_q;
    assign rx_byte    = rx_sh;

    // Sequencing: divider tick, half-period index, clock phase, end of byte.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            tick     <= '0;
            half_idx <= '0;
            phase    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q   <= 1'b1;
                tick     <= '0;
                half_idx <= '0;
                phase    <= 1'b0;
            end else if (half_end) begin
                tick     <= '0;
                phase    <= ~phase;
                half_idx <= half_idx + 4'd1;
                if (half_idx == LAST_HALF) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (busy_q) begin
                tick <= tick + DIV_W'(1);
            end
        end
    end

    // Data path: load, drive the next output bit, capture the input bit.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            mosi_q <= 1'b0;
        end else if (start && !busy_q) begin
            if (lead_sample) begin
                mosi_q <= tx_byte[7];
                tx_sh  <= {tx_byte[6:0], 1'b0};
            end else begin
                tx_sh  <= tx_byte;
            end
        end else begin
            if (do_drive) begin
                mosi_q <= tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
            end
            if (do_sample) rx_sh <= {rx_sh[6:0], sample_bit};
        end
    end

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !busy_q |-> (sclk == idle_high));

endmodule

// File: rtl/spim_regs.sv
// Register file and state control: holds configuration, divider and limits,
// runs the settle window after each state change, decodes software reset
// and builds the read data.
// Assumes: one register access per cycle; reads have no side effect here.
module spim_regs
    import spim_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 2,
    parameter int SETTLE    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             tx_full,
    input  logic             tx_ne,
    input  logic             rx_ne,
    input  logic             out_done,
    input  logic [7:0]       rx_head,
    output logic [REG_W-1:0] reg_rdata,
    output cfg_t             cfg,
    output logic [DIV_W-1:0] half_div,
    output logic [CNT_W-1:0] out_limit,
    output logic [CNT_W-1:0] in_limit,
    output core_state_e      state,
    output logic             st_valid,
    output logic             sw_clear
);
    localparam int SW = $clog2(SETTLE + 1);

    logic [SW-1:0]    settle;
    logic             st_acc;
    logic [CFG_W-1:0] cfg_bits;

    assign sw_clear = reg_wr && (reg_addr == A_SWRST) && reg_wdata[0];
    assign st_valid = (settle == '0);
    assign st_acc   = reg_wr && (reg_addr == A_STATE) && st_valid &&
                      (reg_wdata[1:0] != 2'b10);
    assign cfg_bits = cfg;

    // State code and settle window.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) begin
            state  <= ST_RESET;
            settle <= '0;
        end else if (st_acc) begin
            state  <= core_state_e'(reg_wdata[1:0]);
            settle <= SW'(SETTLE);
        end else if (!st_valid) begin
            settle <= settle - SW'(1);
        end
    end

    // Configuration, divider and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) begin
            cfg       <= '0;
            half_div  <= DIV_W'(DIV_RESET);
            out_limit <= '0;
            in_limit  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CFG:   cfg       <= cfg_t'(reg_wdata[CFG_W-1:0]);
                A_DIV:   half_div  <= reg_wdata[DIV_W-1:0];
                A_OLIM:  out_limit <= reg_wdata[CNT_W-1:0];
                A_ILIM:  in_limit  <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read data selection.
    always_comb begin
        case (reg_addr)
            A_STATE: reg_rdata = REG_W'({st_valid, state});
            A_CFG:   reg_rdata = REG_W'(cfg_bits);
            A_DIV:   reg_rdata = REG_W'(half_div);
            A_OLIM:  reg_rdata = REG_W'(out_limit);
            A_ILIM:  reg_rdata = REG_W'(in_limit);
            A_STAT:  reg_rdata = REG_W'({out_done, rx_ne, tx_ne, tx_full});
            A_RXD:   reg_rdata = REG_W'(rx_head);
            default: reg_rdata = '0;
        endcase
    end

    // R2
    settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_acc && !sw_clear) |=> !st_valid);

    // R2
    settle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid && $past(!st_valid)) |=> st_valid);

    // R3
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid && !sw_clear) |=> $stable(state));

endmodule

// File: rtl/spim_core.sv
// SPI master top: ties the register file, the two byte queues and the serial
// engine together, gates byte starts on state, limits and queue space, and
// counts bytes sent and stored in the current run.
// Assumes: the reset state holds the engine idle and keeps both queues empty.
module spim_core
    import spim_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8,
    parameter int DIV_RESET  = 2,
    parameter int SETTLE     = 2,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    output logic        mosi_oe,
    input  logic        miso
);
    cfg_t             cfg;
    core_state_e      state;
    logic             st_valid, sw_clear;
    logic [DIV_W-1:0] half_div;
    logic [CNT_W-1:0] out_limit, in_limit, out_sent, in_recv;
    logic             out_done, in_done, in_reset, core_clr, eng_rst_n;
    logic             tx_push, tx_full, tx_empty, rx_full, rx_empty, rx_pop, rx_store;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic             eng_busy, byte_done, start;

    assign in_reset  = (state == ST_RESET);
    assign core_clr  = sw_clear || in_reset;
    assign eng_rst_n = rst_n && !core_clr;
    assign out_done  = (out_limit != '0) && (out_sent == out_limit);
    assign in_done   = (in_limit != '0) && (in_recv == in_limit);
    assign tx_push   = reg_wr && (reg_addr == A_TXD) && !in_reset && !out_done;
    assign rx_pop    = reg_rd && (reg_addr == A_RXD);
    assign rx_store  = byte_done && cfg.in_en && !in_done;
    assign start     = (state == ST_RUN) && !eng_busy && !byte_done && !tx_empty &&
                       !out_done && !(cfg.in_en && !in_done && rx_full);
    assign mosi_oe   = cfg.keep_drive || eng_busy;

    spim_regs #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .SETTLE(SETTLE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_full(tx_full), .tx_ne(!tx_empty),
        .rx_ne(!rx_empty), .out_done(out_done), .rx_head(rx_head),
        .reg_rdata(reg_rdata), .cfg(cfg), .half_div(half_div),
        .out_limit(out_limit), .in_limit(in_limit), .state(state),
        .st_valid(st_valid), .sw_clear(sw_clear)
    );

    spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(core_clr), .push(tx_push),
        .wdata(reg_wdata[7:0]), .pop(start), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(core_clr), .push(rx_store),
        .wdata(rx_byte), .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .srst_n(eng_rst_n), .start(start), .tx_byte(tx_head),
        .half_div(half_div), .idle_high(cfg.idle_high),
        .lead_sample(cfg.lead_sample), .out_en(cfg.out_en),
        .loopback(cfg.loopback), .miso(miso), .busy(eng_busy),
        .byte_done(byte_done), .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi)
    );

    // Per-run byte counters for the send and receive limits.
    always_ff @(posedge clk) begin
        if (!rst_n || core_clr) begin
            out_sent <= '0;
            in_recv  <= '0;
        end else if (byte_done) begin
            out_sent <= out_sent + CNT_W'(1);
            if (rx_store) in_recv <= in_recv + CNT_W'(1);
        end
    end

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(state == ST_RUN && !out_done));

    // R12
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && $past(in_reset)) |-> (tx_empty && rx_empty));

    // R13
    swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (state == ST_RESET && st_valid && tx_empty && rx_empty));

endmodule

// File: tb/spim_core_bench.sv
`timescale 1ns/1ps
module spim_core_bench;
    localparam logic [3:0] A_STATE = 4'd0, A_CFG = 4'd1, A_DIV = 4'd2,
                           A_OLIM = 4'd3, A_ILIM = 4'd4, A_STAT = 4'd5,
                           A_TXD = 4'd6, A_RXD = 4'd7, A_SWRST = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, mosi, mosi_oe, miso;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // monitor state
    bit       mon_idle, mon_lead;
    int       mon_edges, mon_perr, mon_half;
    logic [7:0] mon_sh;
    time      mon_last;

    always #2.5 clk = ~clk;

    assign miso = ~mosi;

    spim_core u_spim_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
    );

    // Serial monitor: captures mosi on the receiver's sampling edge and
    // checks the spacing of edges inside a byte.
    always @(sclk) begin
        if ((sclk != mon_idle) == mon_lead) mon_sh = {mon_sh[6:0], mosi};
        if ((mon_edges % 16) != 0 && ($time - mon_last) != time'(mon_half * 5))
            mon_perr++;
        mon_edges++;
        mon_last = $time;
    end

    task automatic mon_clear(input bit idle, input bit lead, input int half);
        mon_idle = idle; mon_lead = lead; mon_half = half;
        mon_edges = 0; mon_perr = 0; mon_sh = '0;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pop_rx(output logic [15:0] d);
        @(negedge clk);
        reg_addr = A_RXD; reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_state(input logic [1:0] s);
        logic [15:0] d;
        wr(A_STATE, {14'd0, s});
        for (int i = 0; i < 10; i++) begin
            peek(A_STATE, d);
            if (d[2]) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rx();
        logic [15:0] d;
        for (int i = 0; i < 2000; i++) begin
            peek(A_STAT, d);
            if (d[2]) break;
            @(negedge clk);
        end
        wait_cycles(2);
    endtask

    // Watchdog.
    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        mon_clear(1'b0, 1'b1, 2);
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset values
        peek(A_STATE, d); check("R1 state", d, 16'h0004);
        peek(A_CFG, d);   check("R1 cfg", d, 16'h0000);
        peek(A_DIV, d);   check("R1 div", d, 16'h0002);
        peek(A_OLIM, d);  check("R1 olim", d, 16'h0000);
        peek(A_ILIM, d);  check("R1 ilim", d, 16'h0000);
        peek(A_STAT, d);  check("R1 stat", d, 16'h0000);
        check("R1 sclk", {15'd0, sclk}, 16'd0);
        check("R1 oe", {15'd0, mosi_oe}, 16'd0);

        // R2 settle window and R3 ignored writes
        wr(A_STATE, 16'h0001);
        peek(A_STATE, d); check("R2 settle c1", d, 16'h0001);
        @(negedge clk); peek(A_STATE, d); check("R2 settle c2", d, 16'h0001);
        @(negedge clk); peek(A_STATE, d); check("R2 settle c3", d, 16'h0005);
        wr(A_STATE, 16'h0003);
        wr(A_STATE, 16'h0000);           // lands while the flag is low
        wait_cycles(3);
        peek(A_STATE, d); check("R3 write during settle", d, 16'h0007);
        wr(A_STATE, 16'h0002);           // unused code
        peek(A_STATE, d); check("R3 unused code", d, 16'h0007);
        set_state(2'b00);
        peek(A_STATE, d); check("R2 back to reset", d, 16'h0004);

        // R14 output enable while idle
        check("R14 oe idle", {15'd0, mosi_oe}, 16'd0);
        wr(A_CFG, 16'h0020);
        peek(A_CFG, d);
        check("R14 oe keep", {15'd0, mosi_oe}, 16'd1);

        // R5 R6 R7 mode / divider / sampler source sweep
        for (int m = 0; m < 4; m++) begin
            for (int di = 0; di < 3; di++) begin
                for (int k = 0; k < 2; k++) begin
                    bit idle, lead;
                    int dv, eff;
                    logic [7:0] tx, exp_rx;
                    idle = (m >= 2);
                    lead = (m == 0 || m == 2);
                    dv   = (di == 0) ? 0 : (di == 1) ? 1 : 3;
                    eff  = (dv == 0) ? 1 : dv;
                    tx   = 8'(m * 53 + di * 29 + k * 101 + 7);
                    exp_rx = k ? tx : ~tx;
                    set_state(2'b00);
                    wr(A_CFG, {10'd0, 1'b1, lead, idle, k[0], 1'b1, 1'b1});
                    wr(A_DIV, 16'(dv));
                    #1;
                    check("R5 idle level", {15'd0, sclk}, {15'd0, idle});
                    set_state(2'b01);
                    mon_clear(idle, lead, eff);
                    wr(A_TXD, {8'd0, tx});
                    wait_rx();
                    pop_rx(d);
                    check(k ? "R7 loopback byte" : "R7 external byte", d, {8'd0, exp_rx});
                    check("R5 bits on sample edge", {8'd0, mon_sh}, {8'd0, tx});
                    check("R6 edge count", 16'(mon_edges), 16'd16);
                    check("R6 edge spacing", 16'(mon_perr), 16'd0);
                end
            end
        end

        // R14 busy drives output, out_en=0 sends ones, in_en=0 stores nothing
        set_state(2'b00);
        wr(A_CFG, 16'h0007); wr(A_DIV, 16'd3); wr(A_OLIM, 0); wr(A_ILIM, 0);
        mon_clear(1'b0, 1'b0, 3);
        set_state(2'b01);
        wr(A_TXD, 16'h0042);
        wait_cycles(3);
        check("R14 oe busy", {15'd0, mosi_oe}, 16'd1);
        wait_rx(); pop_rx(d);
        check("R14 oe done", {15'd0, mosi_oe}, 16'd0);
        set_state(2'b00);
        wr(A_CFG, 16'h0006); wr(A_DIV, 16'd1);
        set_state(2'b01);
        wr(A_TXD, 16'h0000);
        wait_rx(); pop_rx(d);
        check("R14 out disabled gives ones", d, 16'h00FF);
        set_state(2'b00);
        wr(A_CFG, 16'h0005);
        set_state(2'b01);
        wr(A_TXD, 16'h005A);
        wait_cycles(100);
        peek(A_STAT, d);
        check("R14 in disabled", d, 16'h0000);

        // R4 pause holds, reset ignores pushes
        set_state(2'b00);
        wr(A_TXD, 16'h0011);
        peek(A_STAT, d); check("R4 push in reset", d, 16'h0000);
        wr(A_CFG, 16'h0007); wr(A_DIV, 16'd1);
        set_state(2'b11);
        wr(A_TXD, 16'h0011); wr(A_TXD, 16'h0012);
        wait_cycles(100);
        peek(A_STAT, d); check("R4 pause holds", d, 16'h0002);
        check("R4 sclk idle in pause", {15'd0, sclk}, 16'd0);
        set_state(2'b01);
        wait_cycles(100);
        pop_rx(d); check("R4 run byte0", d, 16'h0011);
        pop_rx(d); check("R4 run byte1", d, 16'h0012);

        // R8 send limit
        set_state(2'b00);
        wr(A_OLIM, 16'd3);
        set_state(2'b11);
        for (int i = 0; i < 5; i++) wr(A_TXD, 16'(8'h10 + i));
        set_state(2'b01);
        wait_cycles(200);
        peek(A_STAT, d); check("R8 limit reached, 2 left", d, 16'h000E);
        for (int i = 0; i < 3; i++) begin
            pop_rx(d); check("R8 limited byte", d, 16'(8'h10 + i));
        end
        peek(A_STAT, d); check("R8 only limit received", d, 16'h000A);
        set_state(2'b00);
        wr(A_OLIM, 16'd2);
        set_state(2'b01);
        wr(A_TXD, 16'h0021); wr(A_TXD, 16'h0022);
        wait_cycles(150);
        pop_rx(d); pop_rx(d);
        wr(A_TXD, 16'h0023);
        peek(A_STAT, d); check("R8 push after limit ignored", d, 16'h0008);

        // R9 receive limit
        set_state(2'b00);
        wr(A_OLIM, 16'd4); wr(A_ILIM, 16'd2);
        set_state(2'b11);
        for (int i = 0; i < 4; i++) wr(A_TXD, 16'(8'h20 + i));
        set_state(2'b01);
        wait_cycles(200);
        pop_rx(d); check("R9 byte0", d, 16'h0020);
        pop_rx(d); check("R9 byte1", d, 16'h0021);
        peek(A_STAT, d); check("R9 rest dropped, all sent", d, 16'h0008);

        // R10 zero limits
        set_state(2'b00);
        wr(A_OLIM, 16'd0); wr(A_ILIM, 16'd0);
        set_state(2'b11);
        for (int i = 0; i < 6; i++) wr(A_TXD, 16'(8'h40 + i));
        set_state(2'b01);
        wait_cycles(250);
        for (int i = 0; i < 6; i++) begin
            pop_rx(d); check("R10 unbounded byte", d, 16'(8'h40 + i));
        end
        peek(A_STAT, d); check("R10 no limit flag", d, 16'h0000);

        // R11 full queue, overflow dropped
        set_state(2'b00);
        set_state(2'b11);
        for (int i = 0; i < 8; i++) wr(A_TXD, 16'(8'h30 + i));
        peek(A_STAT, d); check("R11 full flag", d, 16'h0003);
        wr(A_TXD, 16'h0099);
        set_state(2'b01);
        wait_cycles(350);
        for (int i = 0; i < 8; i++) begin
            pop_rx(d); check("R11 queued byte", d, 16'(8'h30 + i));
        end
        peek(A_STAT, d); check("R11 overflow dropped", d, 16'h0000);

        // R12 reset state flushes both queues
        wr(A_TXD, 16'h0051); wr(A_TXD, 16'h0052);
        wait_cycles(100);
        set_state(2'b11);
        wr(A_TXD, 16'h0053);
        peek(A_STAT, d); check("R12 before flush", d, 16'h0006);
        set_state(2'b00);
        peek(A_STAT, d); check("R12 flushed", d, 16'h0000);

        // R13 software reset
        wr(A_CFG, 16'h003F); wr(A_DIV, 16'd7); wr(A_OLIM, 16'd5); wr(A_ILIM, 16'd9);
        set_state(2'b11);
        wr(A_TXD, 16'h0061);
        wr(A_SWRST, 16'h0001);
        peek(A_STATE, d); check("R13 state", d, 16'h0004);
        peek(A_CFG, d);   check("R13 cfg", d, 16'h0000);
        peek(A_DIV, d);   check("R13 div", d, 16'h0002);
        peek(A_OLIM, d);  check("R13 olim", d, 16'h0000);
        peek(A_ILIM, d);  check("R13 ilim", d, 16'h0000);
        peek(A_STAT, d);  check("R13 stat", d, 16'h0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule